// File: doc/BRIEF.md
# Page Access Permission Judge

This unit sits behind a reference-style page table walk and decides whether a translated access may proceed. For each request it takes the kind of access (load, store, instruction fetch, or a combined store-and-fetch atomic), the privilege of the requester, a no-fault mode bit, and two fields of the final page table entry: the 3-bit permission code and the modified bit. It returns a fault code and the read/write/execute rights to install in the translation cache.

When an access faults, the unit records it in a fault status register and captures the page-aligned virtual address in a fault address register. If an earlier fault was never read out, the status register is first collapsed to an overflow marker before the new fault is merged in. A read strobe empties the status register. All results are registered and appear one clock after the request strobe, together with a one-cycle done pulse.

Top module: `acc_perm_judge`

## Requirements
- R1: The access index is {store, fetch, supervisor} (store bit 2, fetch bit 1, bit 0 set for supervisor); it is recorded in status bits 7:5 on a fault.
- R2: The fault code is 12 (privilege) for a user access to permission code 6 or 7, else 8 (protection) when the access needs a right the code does not give (a load needs read, a store needs write, a fetch needs execute, store-and-fetch needs write and execute), else 0. A faulting request grants no rights.
- R3: With no-fault mode set, a nonzero code from a user access is reported as 0 and the rights of the code are granted; supervisor accesses are not affected.
- R4: Rights, as {read, write, execute} on bits 2:0, come from the permission code: 0 R, 1 RW, 2 RX, 3 RWX, 4 X; for supervisor 5 RW, 6 RX, 7 RWX; for user 5 R, 6 and 7 none.
- R5: When the entry's modified bit is clear, the write right is withheld.
- R6: On a fault into an empty status register, the register becomes (index << 5) | code | 2, bit 1 being the address-valid flag, bit 0 clear.
- R7: On a fault while the status register is nonzero, the register becomes 1 | (index << 5) | code | 2, dropping all earlier content.
- R8: On a fault the address register loads the virtual address with its low PAGE_BITS bits cleared; without a fault it holds.
- R9: A read strobe clears the status register; a fault in the same cycle is logged as into an empty register.
- R10: Results and status appear one cycle after the request strobe with a done pulse of one cycle; after reset all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Check request strobe |
| acc_store | input | 1 | Access writes memory |
| acc_fetch | input | 1 | Access is an instruction fetch |
| acc_super | input | 1 | Requester is supervisor |
| nofault_mode | input | 1 | No-fault mode enable |
| pte_perm | input | 3 | Permission code of the final entry |
| pte_modified | input | 1 | Modified bit of the final entry |
| acc_vaddr | input | VA_W | Virtual address of the access |
| fsr_read | input | 1 | Status register read strobe |
| done | output | 1 | Result valid pulse |
| fault_code | output | 4 | 0, 8 or 12 |
| rights | output | 3 | Granted {read, write, execute} |
| fsr | output | 8 | Fault status register |
| far | output | VA_W | Fault address register |

## Verification
The hardest state to reach is the overflow merge: the status register must already hold an unread fault when a second fault arrives, and the case where a read strobe and a fault coincide must leave no overflow flag. The stimulus walks all 64 index and permission pairs with both modified values, reading the status register only after every third request so faults pile up, then adds directed requests with a read strobe in the same cycle and no-fault mode sweeps for both privileges.

// File: rtl/apj_pkg.sv
package apj_pkg;
  localparam int IDX_W  = 3;
  localparam int PERM_W = 3;
  localparam int CODE_W = 4;
  localparam int RGT_W  = 3;
  localparam int STAT_W = IDX_W + 5;

  localparam logic [CODE_W-1:0] CODE_OK   = 4'd0;
  localparam logic [CODE_W-1:0] CODE_PROT = 4'd8;
  localparam logic [CODE_W-1:0] CODE_PRIV = 4'd12;

  localparam int RB_R = 2;
  localparam int RB_W = 1;
  localparam int RB_X = 0;

  localparam logic [STAT_W-1:0] ST_OVF   = 8'h01;
  localparam logic [STAT_W-1:0] ST_VALID = 8'h02;

  function automatic logic [RGT_W-1:0] code_rights(input logic [PERM_W-1:0] perm,
                                                    input logic sup);
    logic [RGT_W-1:0] r;
    case (perm)
      3'd0: r = 3'b100;
      3'd1: r = 3'b110;
      3'd2: r = 3'b101;
      3'd3: r = 3'b111;
      3'd4: r = 3'b001;
      3'd5: r = sup ? 3'b110 : 3'b100;
      3'd6: r = sup ? 3'b101 : 3'b000;
      default: r = sup ? 3'b111 : 3'b000;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/apj_perm_lut.sv
module apj_perm_lut
  import apj_pkg::*;
(
  input  logic [IDX_W-1:0]  idx,
  input  logic [PERM_W-1:0] perm,
  output logic [RGT_W-1:0]  grant,
  output logic [CODE_W-1:0] code
);
  logic             sup;
  logic             is_st;
  logic             is_fe;
  logic [RGT_W-1:0] need;

  assign sup   = idx[0];
  assign is_fe = idx[1];
  assign is_st = idx[2];

  always_comb begin
    grant        = code_rights(perm, sup);
    need         = '0;
    need[RB_R]   = ~is_st & ~is_fe;
    need[RB_W]   = is_st;
    need[RB_X]   = is_fe;
    if (!sup && perm[2:1] == 2'b11)
      code = CODE_PRIV;
    else if ((need & ~grant) != '0)
      code = CODE_PROT;
    else
      code = CODE_OK;
  end
endmodule

// File: rtl/apj_fault_log.sv
module apj_fault_log
  import apj_pkg::*;
#(
  parameter int VA_W      = 32,
  parameter int PAGE_BITS = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              log_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [CODE_W-1:0] code,
  input  logic [VA_W-1:0]   vaddr,
  input  logic              rd_clr,
  output logic [STAT_W-1:0] fsr_q,
  output logic [VA_W-1:0]   far_q
);
  localparam logic [VA_W-1:0] PAGE_MASK = ~((VA_W'(1) << PAGE_BITS) - VA_W'(1));

  logic [STAT_W-1:0] prior;
  logic [STAT_W-1:0] merged;

  always_comb begin
    prior  = rd_clr ? '0 : fsr_q;
    merged = (prior != '0) ? ST_OVF : '0;
    merged = merged | {idx, 5'b0} | STAT_W'(code) | ST_VALID;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fsr_q <= '0;
      far_q <= '0;
    end else if (log_en) begin
      fsr_q <= merged;
      far_q <= vaddr & PAGE_MASK;
    end else if (rd_clr) begin
      fsr_q <= '0;
    end
  end
endmodule

// File: rtl/acc_perm_judge.sv
module acc_perm_judge
  import apj_pkg::*;
#(
  parameter int VA_W      = 32,
  parameter int PAGE_BITS = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              acc_store,
  input  logic              acc_fetch,
  input  logic              acc_super,
  input  logic              nofault_mode,
  input  logic [PERM_W-1:0] pte_perm,
  input  logic              pte_modified,
  input  logic [VA_W-1:0]   acc_vaddr,
  input  logic              fsr_read,
  output logic              done,
  output logic [CODE_W-1:0] fault_code,
  output logic [RGT_W-1:0]  rights,
  output logic [STAT_W-1:0] fsr,
  output logic [VA_W-1:0]   far
);
  logic [IDX_W-1:0]  acc_idx;
  logic [RGT_W-1:0]  tbl_grant;
  logic [CODE_W-1:0] tbl_code;
  logic [CODE_W-1:0] final_code;
  logic [RGT_W-1:0]  final_grant;
  logic              suppress;

  assign acc_idx = {acc_store, acc_fetch, acc_super};

  apj_perm_lut u_lut (
    .idx   (acc_idx),
    .perm  (pte_perm),
    .grant (tbl_grant),
    .code  (tbl_code)
  );

  always_comb begin
    suppress    = nofault_mode && !acc_super;
    final_code  = suppress ? CODE_OK : tbl_code;
    final_grant = tbl_grant;
    if (!pte_modified) final_grant[RB_W] = 1'b0;
    if (final_code != CODE_OK) final_grant = '0;
  end

  apj_fault_log #(.VA_W(VA_W), .PAGE_BITS(PAGE_BITS)) u_log (
    .clk    (clk),
    .rst    (rst),
    .log_en (req && (final_code != CODE_OK)),
    .idx    (acc_idx),
    .code   (final_code),
    .vaddr  (acc_vaddr),
    .rd_clr (fsr_read),
    .fsr_q  (fsr),
    .far_q  (far)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done       <= 1'b0;
      fault_code <= '0;
      rights     <= '0;
    end else begin
      done <= req;
      if (req) begin
        fault_code <= final_code;
        rights     <= final_grant;
      end
    end
  end
endmodule

// File: rtl/apj_checker.sv
module apj_checker #(
  parameter int VA_W = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            req,
  input logic            fsr_read,
  input logic            pte_modified,
  input logic            done,
  input logic [3:0]      fault_code,
  input logic [2:0]      rights,
  input logic [7:0]      fsr,
  input logic [VA_W-1:0] far
);
  p_done_after_req_r10: assert property (@(posedge clk) disable iff (rst) req |=> done);
  p_done_idle_r10: assert property (@(posedge clk) disable iff (rst) !req |=> !done);
  p_code_set_r2: assert property (@(posedge clk) disable iff (rst)
    done |-> (fault_code == 4'd0 || fault_code == 4'd8 || fault_code == 4'd12));
  p_fault_no_grant_r2: assert property (@(posedge clk) disable iff (rst)
    (done && fault_code != 4'd0) |-> rights == 3'b000);
  p_write_needs_mod_r5: assert property (@(posedge clk) disable iff (rst)
    (done && !$past(pte_modified)) |-> !rights[1]);
  p_fault_valid_r6: assert property (@(posedge clk) disable iff (rst)
    (done && fault_code != 4'd0) |-> fsr[1]);
  p_far_on_fault_r8: assert property (@(posedge clk) disable iff (rst)
    !$stable(far) |-> (done && fault_code != 4'd0));
  p_read_clears_r9: assert property (@(posedge clk) disable iff (rst)
    (fsr_read && !req) |=> fsr == 8'h00);
endmodule

bind acc_perm_judge apj_checker #(.VA_W(VA_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .req          (req),
  .fsr_read     (fsr_read),
  .pte_modified (pte_modified),
  .done         (done),
  .fault_code   (fault_code),
  .rights       (rights),
  .fsr          (fsr),
  .far          (far)
);

// File: tb/sim_acc_perm_judge.sv
module sim_acc_perm_judge;
  localparam int VA_W = 32;
  localparam int PB   = 12;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            req = 1'b0, st = 1'b0, fe = 1'b0, su = 1'b0, nf = 1'b0;
  logic [2:0]      perm = '0;
  logic            mod = 1'b0;
  logic [VA_W-1:0] va = '0;
  logic            rd = 1'b0;
  logic            done;
  logic [3:0]      code;
  logic [2:0]      rights;
  logic [7:0]      fsr;
  logic [VA_W-1:0] far;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  typedef struct {
    logic [3:0]      code;
    logic [2:0]      rights;
    logic [7:0]      fsr;
    logic [VA_W-1:0] far;
    bit              nfsup;
  } exp_t;
  exp_t q[$];

  logic [7:0]      m_fsr = '0;
  logic [VA_W-1:0] m_far = '0;

  always #4 clk = ~clk;

  acc_perm_judge #(.VA_W(VA_W), .PAGE_BITS(PB)) u0 (
    .clk(clk), .rst(rst), .req(req), .acc_store(st), .acc_fetch(fe),
    .acc_super(su), .nofault_mode(nf), .pte_perm(perm), .pte_modified(mod),
    .acc_vaddr(va), .fsr_read(rd), .done(done), .fault_code(code),
    .rights(rights), .fsr(fsr), .far(far)
  );

  function automatic logic [3:0] ref_code(input logic [2:0] idx, input logic [2:0] p);
    logic [31:0] row;
    case (idx)
      3'd0: row = 32'hCC080000;
      3'd1: row = 32'h00080000;
      3'd2: row = 32'hCC800088;
      3'd3: row = 32'h00800088;
      3'd4: row = 32'hCC880808;
      3'd5: row = 32'h08080808;
      3'd6: row = 32'hCC880888;
      default: row = 32'h08880888;
    endcase
    return row[p*4 +: 4];
  endfunction

  function automatic logic [2:0] ref_rights(input logic s, input logic [2:0] p);
    logic [2:0] sv [8] = '{3'b100, 3'b110, 3'b101, 3'b111, 3'b001, 3'b110, 3'b101, 3'b111};
    logic [2:0] us [8] = '{3'b100, 3'b110, 3'b101, 3'b111, 3'b001, 3'b100, 3'b000, 3'b000};
    return s ? sv[p] : us[p];
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // driver: one request, optional same-cycle status read
  task automatic issue(input logic s_st, input logic s_fe, input logic s_su, input logic s_nf,
                       input logic [2:0] s_p, input logic s_mod, input logic [VA_W-1:0] s_va,
                       input logic s_rd);
    exp_t e;
    logic [2:0] idx;
    logic [3:0] c;
    logic [7:0] prior;
    idx = {s_st, s_fe, s_su};
    c = ref_code(idx, s_p);
    if (s_nf && !s_su) c = 4'd0;
    e.code = c;
    e.rights = (c != 0) ? 3'b000 : (ref_rights(s_su, s_p) & (s_mod ? 3'b111 : 3'b101));
    prior = s_rd ? 8'h00 : m_fsr;
    if (c != 0) begin
      m_fsr = ((prior != 0) ? 8'h01 : 8'h00) | {idx, 5'b0} | {4'b0, c} | 8'h02;
      m_far = {s_va[VA_W-1:PB], {PB{1'b0}}};
    end else begin
      m_fsr = prior;
    end
    e.fsr = m_fsr;
    e.far = m_far;
    e.nfsup = s_nf && !s_su && (ref_code(idx, s_p) != 0);
    q.push_back(e);
    st = s_st; fe = s_fe; su = s_su; nf = s_nf; perm = s_p; mod = s_mod; va = s_va;
    rd = s_rd; req = 1'b1;
    @(negedge clk);
    req = 1'b0; rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic read_fsr();
    rd = 1'b1;
    m_fsr = '0;
    @(negedge clk);
    rd = 1'b0;
    check(fsr == 8'h00, "R9 status cleared by read", fsr, 8'h00);
  endtask

  // monitor
  always @(negedge clk) begin
    if (!rst && done) begin
      if (q.size() == 0) begin
        check(1'b0, "R10 done without request", 1, 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        check(code == e.code, e.nfsup ? "R3 no-fault code" : "R2 fault code", code, e.code);
        check(rights == e.rights, "R4 R5 granted rights", rights, e.rights);
        check(fsr == e.fsr, "R1 R6 R7 R9 fault status", fsr, e.fsr);
        check(far == e.far, "R8 fault address", far, e.far);
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check({done, code, rights, fsr, far} == '0, "R10 reset state", {done, code, rights, fsr}, 0);

    // R2 R4 R5 R6 R7: full sweep, status read only every third request
    n = 0;
    for (int i = 0; i < 8; i++)
      for (int p = 0; p < 8; p++)
        for (int m = 0; m < 2; m++) begin
          issue(i[2], i[1], i[0], 1'b0, p[2:0], m[0], 32'h1234_5000 + VA_W'(n * 32'h0001_1357), 1'b0);
          n++;
          if (n % 3 == 0) read_fsr();
        end

    // R6: fault into empty register (no overflow bit)
    read_fsr();
    issue(1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 1'b1, 32'hDEAD_BEEF, 1'b0);
    // R7: second unread fault sets overflow
    issue(1'b0, 1'b1, 1'b0, 1'b0, 3'd7, 1'b1, 32'h0000_0FFF, 1'b0);
    // R9: read in same cycle as a fault, no overflow
    issue(1'b0, 1'b0, 1'b1, 1'b0, 3'd4, 1'b0, 32'hFFFF_F123, 1'b1);
    // R8: non-faulting access keeps address
    issue(1'b0, 1'b0, 1'b1, 1'b0, 3'd3, 1'b1, 32'hAAAA_AAAA, 1'b0);
    // R9: same-cycle read with no fault empties register
    issue(1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 1'b1, 32'h5555_5555, 1'b1);

    // R3: no-fault mode for both privileges
    for (int i = 0; i < 8; i++)
      for (int p = 0; p < 8; p++)
        issue(i[2], i[1], i[0], 1'b1, p[2:0], p[0], 32'h0BAD_0000 + VA_W'(p << 12), 1'b0);

    repeat (3) @(negedge clk);
    check(q.size() == 0, "R10 all requests answered", q.size(), 0);
    finish_run();
  end
endmodule